// File: doc/BRIEF.md
# Iterative Integer Multiplier with Upper-Half Significance Flags

This block multiplies two N-bit integers the way a processor's multiply instruction does. It supports three operation kinds. Unsigned and signed multiplies return a double-width product, split into a high half and a low half. A signed immediate multiply returns only the low N bits. In that third kind the immediate is either a full N-bit value or a byte that is sign-extended to N bits. Two flags, carry and overflow, always agree. They report whether the upper half of the result holds information or is only a zero or sign fill.

The caller presents the operands and the mode selects, and pulses `start`. The unit works through one multiplier bit per clock with a shift-and-add datapath. Signed operands are turned into magnitudes first, and the product's sign is restored at the end. When the result registers are written, `done` is raised for one cycle. The outputs then keep their value until the next operation completes.

Top module: `mul_flagged_unit`

## Requirements
- R1: With `imm_sel`=0 and `sign_sel`=0, the unit writes the unsigned product op_a*op_b. Bits [2N-1:N] go to `prod_hi` and bits [N-1:0] go to `prod_lo`.
- R2: With `imm_sel`=0 and `sign_sel`=1, both operands are taken as two's complement. {`prod_hi`,`prod_lo`} is the 2N-bit two's complement product.
- R3: In unsigned mode, `carry` and `ovf` are both 0 when `prod_hi` is all zero and both 1 otherwise. In every mode `carry` equals `ovf`.
- R4: In signed mode, `carry` and `ovf` are 0 when every bit of `prod_hi` equals bit N-1 of `prod_lo`. Otherwise both are 1.
- R5: With `imm_sel`=1, the multiply is signed whatever `sign_sel` is. `prod_lo` receives the low N bits of the signed product and `prod_hi` is 0.
- R6: With `imm_sel`=1 and `imm_byte`=1, the multiplier is op_b[7:0] sign-extended to N bits. op_b[N-1:8] has no effect on the result.
- R7: With `imm_sel`=1, `carry` and `ovf` are 1 exactly when the full signed product lies outside the signed N-bit range.
- R8: A start accepted at a clock edge raises `done` for exactly one cycle after the Nth following edge. `busy` is high from the accepting edge until that completion edge.
- R9: `prod_hi`, `prod_lo`, `carry` and `ovf` change only at a completion edge. They hold their value in every other cycle.
- R10: A `start` while `busy` is high is ignored. No operands are captured and no extra `done` appears. A start in the `done` cycle is accepted.
- R11: After reset, `busy`, `done`, both product halves and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request; accepted when `busy` is low |
| sign_sel | input | 1 | 1 = signed double-width multiply |
| imm_sel | input | 1 | 1 = signed immediate multiply, N-bit result |
| imm_byte | input | 1 | In immediate mode, 1 = use sign-extended op_b[7:0] |
| op_a | input | N | Multiplicand |
| op_b | input | N | Multiplier or immediate |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| prod_hi | output | N | Upper product half (0 in immediate mode) |
| prod_lo | output | N | Lower product half |
| carry | output | 1 | Upper half significant |
| ovf | output | 1 | Same value as `carry` |

## Verification
The checker keeps its own record of the mode seen on each accepted start. It assumes that `start` is taken only when `busy` is low and that mode inputs matter only at that edge. It also assumes the stimulus never needs more than one outstanding operation. The bench drives all inputs at the falling edge. It changes operands and modes freely while the unit is busy, and it sometimes pulses `start` in mid-operation. This tests that the values captured at acceptance are the only ones used. One start is placed in the very cycle `done` is high, to cover the back-to-back case.

// File: rtl/mulf_pkg.sv
package mulf_pkg;

    typedef enum logic [1:0] {
        MUL_UNS = 2'd0,
        MUL_SGN = 2'd1,
        MUL_IMM = 2'd2
    } mul_mode_e;

    typedef struct packed {
        mul_mode_e mode;
        logic      negate;
    } mul_ctrl_t;

    function automatic mul_mode_e pick_mode(logic sign_sel, logic imm_sel);
        if (imm_sel)       return MUL_IMM;
        else if (sign_sel) return MUL_SGN;
        else               return MUL_UNS;
    endfunction

endpackage

// File: rtl/mulf_prep.sv
module mulf_prep
    import mulf_pkg::*;
#(
    parameter int W     = 16,
    parameter int IMM_W = 8
) (
    input  logic           sign_sel,
    input  logic           imm_sel,
    input  logic           imm_byte,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output mul_ctrl_t      ctrl,
    output logic [W-1:0]   mag_a,
    output logic [W-1:0]   mag_b
);
    logic [W-1:0] b_ext;
    logic         is_signed;
    logic         a_neg;
    logic         b_neg;

    generate
        if (IMM_W < W) begin : g_ext
            always_comb begin
                if (imm_sel && imm_byte)
                    b_ext = {{(W-IMM_W){op_b[IMM_W-1]}}, op_b[IMM_W-1:0]};
                else
                    b_ext = op_b;
            end
        end else begin : g_noext
            logic unused_byte;
            assign unused_byte = imm_byte;
            assign b_ext = op_b;
        end
    endgenerate

    always_comb begin
        ctrl.mode   = pick_mode(sign_sel, imm_sel);
        is_signed   = (ctrl.mode != MUL_UNS);
        a_neg       = is_signed & op_a[W-1];
        b_neg       = is_signed & b_ext[W-1];
        mag_a       = a_neg ? (~op_a + 1'b1) : op_a;
        mag_b       = b_neg ? (~b_ext + 1'b1) : b_ext;
        ctrl.negate = a_neg ^ b_neg;
    end
endmodule

// File: rtl/mulf_core.sv
module mulf_core #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [W-1:0]   mag_a,
    input  logic [W-1:0]   mag_b,
    output logic           busy,
    output logic           last_step,
    output logic [2*W-1:0] prod_next
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  acc_hi;
    logic [W-1:0]  acc_lo;
    logic [W-1:0]  mcand;
    logic [CW-1:0] step_cnt;
    logic [W-1:0]  addend;
    logic [W:0]    sum;

    always_comb begin
        addend    = acc_lo[0] ? mcand : '0;
        sum       = {1'b0, acc_hi} + {1'b0, addend};
        prod_next = {sum, acc_lo[W-1:1]};
        last_step = busy && (step_cnt == CW'(W-1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_hi   <= '0;
            acc_lo   <= '0;
            mcand    <= '0;
            step_cnt <= '0;
            busy     <= 1'b0;
        end else if (busy) begin
            acc_hi   <= prod_next[2*W-1:W];
            acc_lo   <= prod_next[W-1:0];
            step_cnt <= step_cnt + 1'b1;
            if (last_step)
                busy <= 1'b0;
        end else if (load) begin
            acc_hi   <= '0;
            acc_lo   <= mag_b;
            mcand    <= mag_a;
            step_cnt <= '0;
            busy     <= 1'b1;
        end
    end
endmodule

// File: rtl/mulf_finish.sv
module mulf_finish
    import mulf_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2*W-1:0] mag_prod,
    input  mul_ctrl_t      ctrl,
    output logic [W-1:0]   res_hi,
    output logic [W-1:0]   res_lo,
    output logic           upper_used
);
    logic [2*W-1:0] full;
    logic [W-1:0]   full_hi;
    logic [W-1:0]   sign_fill;

    always_comb begin
        full      = ctrl.negate ? (~mag_prod + 1'b1) : mag_prod;
        full_hi   = full[2*W-1:W];
        res_lo    = full[W-1:0];
        sign_fill = {W{full[W-1]}};
        case (ctrl.mode)
            MUL_SGN: begin
                res_hi     = full_hi;
                upper_used = (full_hi != sign_fill);
            end
            MUL_IMM: begin
                res_hi     = '0;
                upper_used = (full_hi != sign_fill);
            end
            default: begin
                res_hi     = full_hi;
                upper_used = |full_hi;
            end
        endcase
    end
endmodule

// File: rtl/mul_flagged_unit.sv
module mul_flagged_unit
    import mulf_pkg::*;
#(
    parameter int W     = 16,
    parameter int IMM_W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         sign_sel,
    input  logic         imm_sel,
    input  logic         imm_byte,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo,
    output logic         carry,
    output logic         ovf
);
    mul_ctrl_t      ctrl_in;
    mul_ctrl_t      ctrl_q;
    logic [W-1:0]   mag_a;
    logic [W-1:0]   mag_b;
    logic           accept;
    logic           last_step;
    logic [2*W-1:0] prod_next;
    logic [W-1:0]   fin_hi;
    logic [W-1:0]   fin_lo;
    logic           fin_flag;

    assign accept = start && !busy;

    mulf_prep #(.W(W), .IMM_W(IMM_W)) u_prep (
        .sign_sel (sign_sel),
        .imm_sel  (imm_sel),
        .imm_byte (imm_byte),
        .op_a     (op_a),
        .op_b     (op_b),
        .ctrl     (ctrl_in),
        .mag_a    (mag_a),
        .mag_b    (mag_b)
    );

    mulf_core #(.W(W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .mag_a     (mag_a),
        .mag_b     (mag_b),
        .busy      (busy),
        .last_step (last_step),
        .prod_next (prod_next)
    );

    mulf_finish #(.W(W)) u_finish (
        .mag_prod   (prod_next),
        .ctrl       (ctrl_q),
        .res_hi     (fin_hi),
        .res_lo     (fin_lo),
        .upper_used (fin_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '{mode: MUL_UNS, negate: 1'b0};
            done    <= 1'b0;
            prod_hi <= '0;
            prod_lo <= '0;
            carry   <= 1'b0;
            ovf     <= 1'b0;
        end else begin
            done <= last_step;
            if (accept)
                ctrl_q <= ctrl_in;
            if (last_step) begin
                prod_hi <= fin_hi;
                prod_lo <= fin_lo;
                carry   <= fin_flag;
                ovf     <= fin_flag;
            end
        end
    end
endmodule

// File: rtl/mulf_checker.sv
module mulf_checker
    import mulf_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         sign_sel,
    input logic         imm_sel,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] prod_hi,
    input logic [W-1:0] prod_lo,
    input logic         carry,
    input logic         ovf
);
    localparam int LW = $clog2(W + 1) + 1;

    logic [LW-1:0] lat;
    logic          active;
    mul_mode_e     cap_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat      <= '0;
            active   <= 1'b0;
            cap_mode <= MUL_UNS;
        end else if (start && !busy) begin
            lat      <= '0;
            active   <= 1'b1;
            cap_mode <= pick_mode(sign_sel, imm_sel);
        end else if (done) begin
            active <= 1'b0;
        end else if (active) begin
            lat <= lat + 1'b1;
        end
    end

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (active && lat == LW'(W)));

    assert_idle_at_done_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_ignore_busy_start_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start && lat < LW'(W-1)) |=> (busy && !done));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({prod_hi, prod_lo, carry, ovf}));

    assert_flag_pair_R3: assert property (@(posedge clk) disable iff (rst)
        carry == ovf);

    assert_unsigned_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (done && cap_mode == MUL_UNS) |-> (carry == (|prod_hi)));

    assert_signed_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (done && cap_mode == MUL_SGN) |-> (carry == (prod_hi != {W{prod_lo[W-1]}})));

    assert_imm_hi_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (done && cap_mode == MUL_IMM) |-> (prod_hi == '0));
endmodule

bind mul_flagged_unit mulf_checker #(.W(W)) u_mulf_checker (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .sign_sel (sign_sel),
    .imm_sel  (imm_sel),
    .busy     (busy),
    .done     (done),
    .prod_hi  (prod_hi),
    .prod_lo  (prod_lo),
    .carry    (carry),
    .ovf      (ovf)
);

// File: tb/tb_mul_flagged_unit.sv
`timescale 1ns/1ps
module tb_mul_flagged_unit;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         sign_sel = 1'b0;
    logic         imm_sel = 1'b0;
    logic         imm_byte = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         busy, done, carry, ovf;
    logic [W-1:0] prod_hi, prod_lo;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mul_flagged_unit #(.W(W), .IMM_W(8)) dut (
        .clk(clk), .rst(rst), .start(start), .sign_sel(sign_sel),
        .imm_sel(imm_sel), .imm_byte(imm_byte), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo),
        .carry(carry), .ovf(ovf)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void ref_calc(input bit sg, input bit im, input bit by,
                                     input logic [W-1:0] a, input logic [W-1:0] b,
                                     output logic [W-1:0] hi, output logic [W-1:0] lo,
                                     output bit f);
        longint sa, sb, p, lim;
        lim = longint'(1) <<< (W-1);
        if (im || sg) begin
            sa = longint'($signed(a));
            sb = (im && by) ? longint'($signed(b[7:0])) : longint'($signed(b));
            p  = sa * sb;
            f  = (p >= lim) || (p < -lim);
            lo = p[W-1:0];
            hi = im ? '0 : p[2*W-1:W];
        end else begin
            p  = longint'({48'b0, a}) * longint'({48'b0, b});
            lo = p[W-1:0];
            hi = p[2*W-1:W];
            f  = (hi != '0);
        end
    endfunction

    // behavioural reference, advanced on every rising edge
    bit           m_busy, m_done, m_flag;
    int           m_left;
    logic [W-1:0] m_hi, m_lo, q_hi, q_lo;
    bit           q_flag;
    string        q_tag, m_tag;

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 0; m_done <= 0; m_left <= 0;
            m_hi <= '0; m_lo <= '0; m_flag <= 0; m_tag <= "R11";
        end else begin
            m_done <= 0;
            if (m_busy) begin
                m_left <= m_left - 1;
                if (m_left == 1) begin
                    m_busy <= 0; m_done <= 1;
                    m_hi <= q_hi; m_lo <= q_lo; m_flag <= q_flag; m_tag <= q_tag;
                end
            end else if (start) begin
                logic [W-1:0] h, l;
                bit fl;
                ref_calc(sign_sel, imm_sel, imm_byte, op_a, op_b, h, l, fl);
                q_hi <= h; q_lo <= l; q_flag <= fl;
                q_tag <= imm_sel ? (imm_byte ? "R6/R7" : "R5/R7")
                                 : (sign_sel ? "R2/R4" : "R1/R3");
                m_busy <= 1; m_left <= W;
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(done == m_done, "R8", "done", done, m_done);
            chk(busy == m_busy, "R8", "busy", busy, m_busy);
            if (m_done) begin
                chk(prod_hi == m_hi, m_tag, "prod_hi", prod_hi, m_hi);
                chk(prod_lo == m_lo, m_tag, "prod_lo", prod_lo, m_lo);
                chk(carry == m_flag && ovf == m_flag, m_tag, "carry/ovf",
                    {carry, ovf}, {m_flag, m_flag});
            end else begin
                chk({prod_hi, prod_lo, carry, ovf} == {m_hi, m_lo, m_flag, m_flag},
                    "R9", "held outputs", {prod_hi, prod_lo}, {m_hi, m_lo});
            end
        end
    end

    task automatic issue(input bit sg, input bit im, input bit by,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        start = 1; sign_sel = sg; imm_sel = im; imm_byte = by; op_a = a; op_b = b;
        @(negedge clk);
        start = 0; op_a = ~a; op_b = ~b; sign_sel = ~sg;
    endtask

    task automatic wait_idle();
        repeat (W + 3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11: reset state
        chk({busy, done, prod_hi, prod_lo, carry, ovf} == '0, "R11", "reset state",
            {prod_hi, prod_lo}, 0);

        // R1 / R3 unsigned
        issue(0, 0, 0, 16'd5, 16'd10);          wait_idle();
        issue(0, 0, 0, 16'h00FF, 16'h0100);     wait_idle();
        issue(0, 0, 0, 16'h0100, 16'h0100);     wait_idle();
        issue(0, 0, 0, 16'hFFFF, 16'hFFFF);     wait_idle();
        // R2 / R4 signed
        issue(1, 0, 0, -16'sd3, 16'sd7);        wait_idle();
        issue(1, 0, 0, 16'h8000, 16'h8000);     wait_idle();
        issue(1, 0, 0, 16'hFFFF, 16'hFFFF);     wait_idle();
        issue(1, 0, 0, 16'd100, -16'sd300);     wait_idle();
        issue(1, 0, 0, 16'd200, 16'd200);       wait_idle();
        issue(1, 0, 0, 16'h8000, 16'h0001);     wait_idle();
        // R5 / R7 full immediate, sign_sel low still signed
        issue(0, 1, 0, 16'hFFFF, 16'd5);        wait_idle();
        issue(0, 1, 0, 16'h1000, 16'd9);        wait_idle();
        // R6 byte immediate, upper bits of op_b are garbage
        issue(0, 1, 1, 16'h1234, 16'hAB12);     wait_idle();
        issue(1, 1, 1, 16'd1000, 16'h55FE);     wait_idle();
        issue(0, 1, 1, 16'd300, 16'h7F80);      wait_idle();

        // R10: start while busy is ignored
        issue(0, 0, 0, 16'd1234, 16'd77);
        repeat (3) @(negedge clk);
        start = 1; sign_sel = 1; op_a = 16'h9999; op_b = 16'h7777;
        @(negedge clk);
        start = 0;
        wait_idle();

        // R10: start in the done cycle is accepted (back-to-back)
        issue(1, 0, 0, 16'd321, -16'sd45);
        while (!done) @(negedge clk);
        start = 1; sign_sel = 0; imm_sel = 0; op_a = 16'd4000; op_b = 16'd20;
        @(negedge clk);
        start = 0;
        wait_idle();

        // R9: outputs hold over a long idle stretch
        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule